// File: doc/BRIEF.md
# Trimmed-Divider Real-Time Clock

This peripheral keeps time in whole seconds from a 32.768 kHz reference clock. A prescaler divides the reference down to a one-per-second tick. A signed trim value can lengthen or shorten one tick period out of every group of ticks, which corrects a slow or fast crystal. Each tick advances a 32-bit seconds register. Software can load that register at any time. A 32-bit alarm register is watched against it.

Software reaches the block through a simple single-cycle register bus: a write strobe with address and data, and a read port driven combinationally from the address. A status register holds two event flags, one for the seconds tick and one for the alarm match, together with one interrupt enable for each flag. The block drives two separate interrupt lines. A parameter picks one of two address layouts.

Top module: `rtcTop`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: The low 16 bits of the divider register hold D. The tick period is D+1 reference cycles. A value of D=0 behaves as D=32767. Any write to the divider register restarts the prescaler, so the next tick comes D+1 cycles after the write edge. With D=0 from reset, the first tick comes 32768 cycles after reset.
- R3: Bits [25:16] of the divider register are a signed 10-bit trim T. Within each group of TRIM_EVERY ticks, the last period lasts D+1+T cycles and never less than 1 cycle. A divider write starts a new group.
- R4: The seconds register increments by one on each tick. A bus write loads it. When a write and a tick fall in the same cycle, the written value is kept.
- R5: Status bit 0 (alarm flag) is set when the seconds register is loaded, by a tick or by a write, with a value equal to the alarm register. Writing the alarm register alone never sets it.
- R6: Status bit 1 (tick flag) is set on every tick, whatever the enable bits hold.
- R7: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it as it is. If the clear and a new event fall in the same cycle, the flag stays set.
- R8: Status bit 3 (tick interrupt enable) and bit 2 (alarm interrupt enable) are plain read/write bits. The tick interrupt is high exactly when bits 3 and 1 are both 1. The alarm interrupt is high exactly when bits 2 and 0 are both 1.
- R9: With MAP_SEL=0, the registers sit at alarm 0x00, seconds 0x04, divider 0x08 and status 0x10. With MAP_SEL=1, they sit at seconds 0x0, alarm 0x4, status 0x8 and divider 0xC. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr (combinational) |
| irqHz | output | 1 | Seconds-tick interrupt |
| irqAlarm | output | 1 | Alarm interrupt |

## Verification
The hardest cases to reach are the collisions: a status clear, or a seconds write, landing on the same edge as a tick. Since a divider write restarts the prescaler, the bench writes the divider and then counts exactly D cycles before issuing the colliding write, so both events share one edge. Trim is seen from the ports by timing the changes of the seconds register over two full trim groups, with a small TRIM_EVERY and a short divide value. The flag and enable logic is also exercised by a seeded random sequence of status and seconds writes against a model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic wrSec;
    logic wrAlm;
    logic wrDiv;
    logic wrStat;
  } rtcStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_SEC  = 3'd1,
    RD_ALM  = 3'd2,
    RD_DIV  = 3'd3,
    RD_STAT = 3'd4
  } rtcRdSel_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int MAP_SEL = 0,
  parameter int AW      = 5,
  parameter int DW      = 32
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic [DW-1:0] secVal,
  input  logic [DW-1:0] almVal,
  input  logic [DW-1:0] divVal,
  input  logic [3:0]    statVal,
  output rtcStrobe_t    strobe,
  output logic [DW-1:0] busRData
);
  logic [AW-1:0] offSec, offAlm, offDiv, offStat;
  rtcRdSel_t rdSel;

  generate
    if (MAP_SEL == 0) begin : g_mapA
      assign offAlm  = AW'(5'h00);
      assign offSec  = AW'(5'h04);
      assign offDiv  = AW'(5'h08);
      assign offStat = AW'(5'h10);
    end else begin : g_mapB
      assign offSec  = AW'(5'h00);
      assign offAlm  = AW'(5'h04);
      assign offStat = AW'(5'h08);
      assign offDiv  = AW'(5'h0C);
    end
  endgenerate

  always_comb begin
    rdSel = RD_NONE;
    if (busAddr == offSec)       rdSel = RD_SEC;
    else if (busAddr == offAlm)  rdSel = RD_ALM;
    else if (busAddr == offDiv)  rdSel = RD_DIV;
    else if (busAddr == offStat) rdSel = RD_STAT;
  end

  always_comb begin
    strobe        = '0;
    strobe.wrSec  = busWe && (rdSel == RD_SEC);
    strobe.wrAlm  = busWe && (rdSel == RD_ALM);
    strobe.wrDiv  = busWe && (rdSel == RD_DIV);
    strobe.wrStat = busWe && (rdSel == RD_STAT);
  end

  always_comb begin
    case (rdSel)
      RD_SEC:  busRData = secVal;
      RD_ALM:  busRData = almVal;
      RD_DIV:  busRData = divVal;
      RD_STAT: busRData = {{(DW-4){1'b0}}, statVal};
      default: busRData = '0;
    endcase
  end
endmodule

// File: rtl/rtc_dpath.sv
module rtc_dpath
  import rtc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int DIVW       = 16,
  parameter int TRIMW      = 10,
  parameter int TRIM_EVERY = 1024,
  parameter int DEF_DIV    = 32767
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtcStrobe_t    strobe,
  input  logic [DW-1:0] wData,
  output logic [DW-1:0] secVal,
  output logic [DW-1:0] almVal,
  output logic [DW-1:0] divVal,
  output logic [3:0]    statVal,
  output logic          irqHz,
  output logic          irqAlarm
);
  localparam int TCW = (TRIM_EVERY > 1) ? $clog2(TRIM_EVERY) : 1;
  localparam int RW  = DIVW + TRIMW;
  localparam int SW  = DIVW + 2;
  localparam int PW  = DIVW + 1;

  logic [RW-1:0]         divReg;
  logic [PW-1:0]         presc, term;
  logic [TCW-1:0]        tickCnt;
  logic [DIVW-1:0]       divEff;
  logic signed [TRIMW-1:0] trimVal;
  logic signed [SW-1:0]  termWide;
  logic                  trimNow, tick;
  logic [DW-1:0]         secs, almReg, secNext;
  logic                  secLoad, alarmHit;
  logic                  hzEn, alEn, hzFlag, alFlag;

  // prescaler terminal count, with trim on the last period of a group
  assign divEff   = (divReg[DIVW-1:0] == '0) ? DIVW'(DEF_DIV) : divReg[DIVW-1:0];
  assign trimVal  = divReg[RW-1:DIVW];
  assign trimNow  = (32'(tickCnt) == TRIM_EVERY - 1);
  assign termWide = $signed({2'b00, divEff}) +
                    (trimNow ? {{(SW-TRIMW){trimVal[TRIMW-1]}}, trimVal} : SW'(0));
  assign term     = termWide[SW-1] ? '0 : termWide[PW-1:0];
  assign tick     = !strobe.wrDiv && (presc >= term);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc   <= '0;
      tickCnt <= '0;
      divReg  <= '0;
    end else if (strobe.wrDiv) begin
      presc   <= '0;
      tickCnt <= '0;
      divReg  <= wData[RW-1:0];
    end else if (tick) begin
      presc   <= '0;
      tickCnt <= trimNow ? '0 : tickCnt + 1'b1;
    end else begin
      presc   <= presc + 1'b1;
    end
  end

  // seconds and alarm
  assign secLoad  = strobe.wrSec || tick;
  assign secNext  = strobe.wrSec ? wData : secs + 1'b1;
  assign alarmHit = secLoad && (secNext == almReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secs   <= '0;
      almReg <= '0;
    end else begin
      if (secLoad)      secs   <= secNext;
      if (strobe.wrAlm) almReg <= wData;
    end
  end

  // status: enables read/write, flags write-one-to-clear with set priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hzEn   <= 1'b0;
      alEn   <= 1'b0;
      hzFlag <= 1'b0;
      alFlag <= 1'b0;
    end else begin
      if (strobe.wrStat) begin
        hzEn <= wData[3];
        alEn <= wData[2];
      end
      hzFlag <= tick     || (hzFlag && !(strobe.wrStat && wData[1]));
      alFlag <= alarmHit || (alFlag && !(strobe.wrStat && wData[0]));
    end
  end

  assign secVal   = secs;
  assign almVal   = almReg;
  assign divVal   = DW'(divReg);
  assign statVal  = {hzEn, alEn, hzFlag, alFlag};
  assign irqHz    = hzFlag && hzEn;
  assign irqAlarm = alFlag && alEn;

  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSec |=> secs == $past(wData)); // R4
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !strobe.wrSec) |=> secs == $past(secs) + 1'b1); // R4
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.wrSec) |=> $stable(secs)); // R4
  AST_HZ_SET: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> hzFlag); // R6
  AST_AL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStat && wData[0] && !alarmHit) |=> !alFlag); // R7
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDiv |=> !$past(tick) && $stable(secs) || $past(strobe.wrSec)); // R2
endmodule

// File: rtl/rtcTop.sv
module rtcTop
  import rtc_pkg::*;
#(
  parameter int MAP_SEL    = 0,
  parameter int TRIM_EVERY = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  output logic        irqHz,
  output logic        irqAlarm
);
  rtcStrobe_t  strobe;
  logic [31:0] secVal, almVal, divVal;
  logic [3:0]  statVal;

  rtc_ctrl #(.MAP_SEL(MAP_SEL), .AW(5), .DW(32)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .secVal  (secVal),
    .almVal  (almVal),
    .divVal  (divVal),
    .statVal (statVal),
    .strobe  (strobe),
    .busRData(busRData)
  );

  rtc_dpath #(.DW(32), .DIVW(16), .TRIMW(10), .TRIM_EVERY(TRIM_EVERY), .DEF_DIV(32767)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wData   (busWData),
    .secVal  (secVal),
    .almVal  (almVal),
    .divVal  (divVal),
    .statVal (statVal),
    .irqHz   (irqHz),
    .irqAlarm(irqAlarm)
  );
endmodule

// File: tb/test_rtcTop.sv
module test_rtcTop;
  localparam int TE = 4;
  localparam logic [4:0] A_ALM = 5'h00, A_SEC = 5'h04, A_DIV = 5'h08, A_STAT = 5'h10;
  localparam logic [4:0] B_SEC = 5'h00, B_ALM = 5'h04, B_STAT = 5'h08, B_DIV = 5'h0C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [4:0]  addr, addrB;
  logic        we, weB;
  logic [31:0] wd, wdB, rd, rdB;
  logic        irqHz, irqAl, irqHzB, irqAlB;
  int total = 0, bad = 0;

  rtcTop #(.MAP_SEL(0), .TRIM_EVERY(TE)) i_rtcTop (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWe(we), .busWData(wd),
    .busRData(rd), .irqHz(irqHz), .irqAlarm(irqAl));

  rtcTop #(.MAP_SEL(1), .TRIM_EVERY(TE)) i_rtcTopB (
    .clk(clk), .rstN(rstN), .busAddr(addrB), .busWe(weB), .busWData(wdB),
    .busRData(rdB), .irqHz(irqHzB), .irqAlarm(irqAlB));

  function automatic int expPeriod(int d, int trim, int idx);
    int p = d + 1 + (((idx % TE) == TE - 1) ? trim : 0);
    return (p < 1) ? 1 : p;
  endfunction

  function automatic logic [31:0] expStat(logic [1:0] en, logic [1:0] fl);
    return {28'd0, en, fl};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wrA(logic [4:0] a, logic [31:0] d);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wrB(logic [4:0] a, logic [31:0] d);
    addrB = a; wdB = d; weB = 1'b1;
    @(negedge clk);
    weB = 1'b0;
  endtask

  task automatic rdA(logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rd;
  endtask

  task automatic rdBt(logic [4:0] a, output logic [31:0] v);
    addrB = a; #1; v = rdB;
  endtask

  // cycles until the seconds register next changes
  task automatic measure(output int k);
    logic [31:0] prev, cur;
    rdA(A_SEC, prev);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      rdA(A_SEC, cur);
    end while (cur == prev && k < 70000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [1:0]  en, fl;
    int k, seed;
    seed = $urandom(32'd1234);
    rstN = 1'b0; we = 1'b0; weB = 1'b0;
    addr = '0; addrB = '0; wd = '0; wdB = '0;
    repeat (3) @(negedge clk);
    rdA(A_SEC, v);  check("R1 seconds", v, 0);
    rdA(A_ALM, v);  check("R1 alarm", v, 0);
    rdA(A_DIV, v);  check("R1 divider", v, 0);
    rdA(A_STAT, v); check("R1 status", v, 0);
    check("R1 irqs", {30'd0, irqHz, irqAl}, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R2: default divider gives 32768-cycle first tick
    measure(k);
    check("R2 default period", k, 32768);
    rdA(A_STAT, v); check("R6 tick flag with enables off", v, 32'h2);

    // R2: programmed divide, R3: trim (+2, -3, clamp)
    wrA(A_DIV, 32'd5);
    for (int i = 0; i < 4; i++) begin measure(k); check("R2 period D=5", k, 6); end
    wrA(A_DIV, (32'd2 << 16) | 32'd5);
    for (int i = 0; i < 8; i++) begin measure(k); check("R3 trim +2", k, expPeriod(5, 2, i)); end
    wrA(A_DIV, (32'h3FD << 16) | 32'd5);
    for (int i = 0; i < 8; i++) begin measure(k); check("R3 trim -3", k, expPeriod(5, -3, i)); end
    wrA(A_DIV, (32'h39C << 16) | 32'd2);
    for (int i = 0; i < 4; i++) begin measure(k); check("R3 trim clamp", k, expPeriod(2, -100, i)); end

    // R7: clear on the tick edge, flag stays set
    wrA(A_DIV, 32'd7);
    repeat (7) @(negedge clk);
    wrA(A_STAT, 32'h2);
    rdA(A_STAT, v); check("R7 set wins over clear", v[1], 1);
    @(negedge clk);
    wrA(A_STAT, 32'h2);
    rdA(A_STAT, v); check("R7 clear", v[1], 0);

    // R4/R5: seconds write on the tick edge wins; alarm uses written value
    @(negedge clk);
    wrA(A_ALM, 32'd500);
    wrA(A_STAT, 32'h3);
    wrA(A_DIV, 32'd7);
    repeat (7) @(negedge clk);
    wrA(A_SEC, 32'd500);
    rdA(A_SEC, v);  check("R4 write wins over tick", v, 500);
    rdA(A_STAT, v); check("R5 alarm on write", v[0], 1);

    // R5: alarm on tick
    @(negedge clk);
    wrA(A_DIV, 32'hFFFF);
    wrA(A_SEC, 32'd100);
    wrA(A_ALM, 32'd102);
    wrA(A_STAT, 32'h3);
    wrA(A_DIV, 32'd3);
    measure(k);
    rdA(A_SEC, v);  check("R4 increment", v, 101);
    rdA(A_STAT, v); check("R5 no alarm before match", v[0], 0);
    measure(k);
    rdA(A_STAT, v); check("R5 alarm on tick", v[0], 1);

    // R8: interrupt gating
    wrA(A_STAT, 32'h4);
    #1; check("R8 alarm irq", {30'd0, irqHz, irqAl}, 32'h1);
    @(negedge clk);
    wrA(A_STAT, 32'h8);
    #1; check("R8 tick irq", {30'd0, irqHz, irqAl}, 32'h2);
    @(negedge clk);

    // R5: alarm write alone never sets the flag
    wrA(A_DIV, 32'hFFFF);
    wrA(A_SEC, 32'd77);
    wrA(A_STAT, 32'h3);
    wrA(A_ALM, 32'd77);
    rdA(A_STAT, v); check("R5 alarm write no event", v[0], 0);
    @(negedge clk);

    // R7/R8 random status and seconds writes against a model
    wrA(A_ALM, 32'h55);
    wrA(A_STAT, 32'h3);
    en = 2'b00; fl = 2'b00;
    for (int i = 0; i < 40; i++) begin
      int op = $urandom % 3;
      if (op == 0) begin
        if ($urandom % 2) begin wrA(A_SEC, 32'h55); fl[0] = 1'b1; end
        else wrA(A_SEC, $urandom | 32'h100);
      end else if (op == 1) begin
        logic [3:0] w = 4'($urandom);
        wrA(A_STAT, {28'd0, w});
        en = w[3:2]; fl = fl & ~w[1:0];
      end else begin
        @(negedge clk);
      end
      rdA(A_STAT, v); check("R7 random status", v, expStat(en, fl));
      check("R8 random irqs", {30'd0, irqHz, irqAl}, {30'd0, en[1] & fl[1], en[0] & fl[0]});
      @(negedge clk);
    end

    // R9: unmapped address on map A, and map B layout
    wrA(5'h0C, 32'hDEAD);
    rdA(5'h0C, v); check("R9 map A unmapped", v, 0);
    wrB(B_DIV, 32'hFFFF);
    wrB(B_SEC, 32'd123);
    wrB(B_ALM, 32'd456);
    wrB(B_STAT, 32'hF);
    rdBt(B_SEC, v);  check("R9 map B seconds", v, 123);
    rdBt(B_ALM, v);  check("R9 map B alarm", v, 456);
    rdBt(B_DIV, v);  check("R9 map B divider", v, 32'hFFFF);
    rdBt(B_STAT, v); check("R9 map B status", v, 32'hC);
    rdBt(5'h10, v);  check("R9 map B unmapped", v, 0);
    summary();
  end
endmodule